// File: doc/BRIEF.md
# Sample Rate Register Quantizer

This block keeps the playback and capture sample-rate registers of a codec's control register file. Software writes a 16-bit rate value through a simple register port. The block does not store that value. It looks only at the top nibble of the written data and replaces the whole value with one of seven supported rate codes. Reads always return the replaced code, never the value that was written.

Writes are accepted only while the variable-rate enable input is high. While that input is low, writes are dropped and both registers read back the 48 kHz code. When the input falls, both registers are reloaded with that same code. So when variable rate is turned on again, both registers start at 48 kHz.

For each register, the current code and a 3-bit rate select are also driven to downstream clock-generation logic. These outputs always equal what a read of that register returns.

Top module: `srq_rate_regs`

## Requirements
- R1: After reset, both registers read BB80h, and both rate-select outputs are 6.
- R2: A write is mapped by data bits [15:12] to a stored code, as follows:
  - 0h to 1h give 1F40h (8 kHz).
  - 2h gives 2B11h (11.025 kHz).
  - 3h gives 3E80h (16 kHz).
  - 4h to 5h give 5622h (22.05 kHz).
  - 6h to 7h give 7D00h (32 kHz).
  - 8h to Ah give AC44h (44.1 kHz).
  - Bh to Fh give BB80h (48 kHz).
- R3: Data bits [11:0] of a write have no effect on the stored code.
- R4: The playback register is at index 2Ch and the capture register is at index 32h. A write to one register leaves the other unchanged.
- R5: While the enable input is 0, writes are ignored, and both registers and both code outputs show BB80h.
- R6: When the enable input returns to 1 after being 0, both registers hold BB80h, whatever they held before it fell.
- R7: A write strobe at any other index changes neither register. A read of any other index returns 0000h.
- R8: A write takes effect at the clock edge where the strobe is sampled. Read data is combinational, so the new code is visible in the following cycle.
- R9: The rate-select outputs encode 8, 11.025, 16, 22.05, 32, 44.1 and 48 kHz as 0 through 6. Each select output always matches its register's code output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| var_rate_en | input | 1 | Variable-rate enable; 0 forces 48 kHz |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write index |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read index |
| rd_data | output | 16 | Read data (combinational) |
| play_code | output | 16 | Current playback rate code |
| play_sel | output | 3 | Current playback rate select (0..6) |
| cap_code | output | 16 | Current capture rate code |
| cap_sel | output | 3 | Current capture rate select (0..6) |

## Verification
The assertions assume that the enable input and the write port are synchronous to the clock and hold steady across each sampling edge. They also assume that a write is meaningful only if the enable was high at that edge. The write-mapping and hold properties therefore check the next cycle only when the enable is still high there. The bench changes all inputs at the falling edge. It toggles the enable only in cycles with no write strobe, so every write lands in a cycle where the enable is known.

// File: rtl/srq_pkg.sv
package srq_pkg;

    localparam int CODE_W = 16;
    localparam int NIB_W  = 4;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SR_8K  = 3'd0,
        SR_11K = 3'd1,
        SR_16K = 3'd2,
        SR_22K = 3'd3,
        SR_32K = 3'd4,
        SR_44K = 3'd5,
        SR_48K = 3'd6
    } rate_sel_e;

    localparam rate_sel_e SR_DEFAULT = SR_48K;

    typedef struct packed {
        rate_sel_e sel;
    } chan_st_t;

    // Range decode of the top nibble onto a supported rate
    function automatic rate_sel_e nib_to_sel(input logic [NIB_W-1:0] nib);
        rate_sel_e s;
        if (nib <= 4'h1)      s = SR_8K;
        else if (nib == 4'h2) s = SR_11K;
        else if (nib == 4'h3) s = SR_16K;
        else if (nib <= 4'h5) s = SR_22K;
        else if (nib <= 4'h7) s = SR_32K;
        else if (nib <= 4'hA) s = SR_44K;
        else                  s = SR_48K;
        return s;
    endfunction

    function automatic logic [CODE_W-1:0] sel_to_code(input rate_sel_e s);
        logic [CODE_W-1:0] c;
        case (s)
            SR_8K:   c = 16'h1F40;
            SR_11K:  c = 16'h2B11;
            SR_16K:  c = 16'h3E80;
            SR_22K:  c = 16'h5622;
            SR_32K:  c = 16'h7D00;
            SR_44K:  c = 16'hAC44;
            default: c = 16'hBB80;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/srq_snap.sv
module srq_snap
    import srq_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output rate_sel_e        sel
);
    always_comb sel = nib_to_sel(nib);
endmodule

// File: rtl/srq_encode.sv
module srq_encode
    import srq_pkg::*;
(
    input  rate_sel_e         sel,
    output logic [CODE_W-1:0] code
);
    always_comb code = sel_to_code(sel);
endmodule

// File: rtl/srq_chan.sv
module srq_chan
    import srq_pkg::*;
#(
    parameter int                ADDR_W = 7,
    parameter logic [ADDR_W-1:0] IDX    = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vr_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output rate_sel_e         sel,
    output logic [CODE_W-1:0] code
);
    localparam int NIB_LSB = CODE_W - NIB_W;

    chan_st_t  st_d, st_q;
    rate_sel_e snap_sel;

    srq_snap u_snap (
        .nib (wr_data[NIB_LSB +: NIB_W]),
        .sel (snap_sel)
    );

    always_comb begin
        st_d = st_q;
        if (!vr_en) begin
            st_d.sel = SR_DEFAULT;
        end else if (wr_en && (wr_addr == IDX)) begin
            st_d.sel = snap_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: SR_DEFAULT};
        else        st_q <= st_d;
    end

    // Forced view while disabled so the readback never lags the enable
    assign sel = vr_en ? st_q.sel : SR_DEFAULT;

    srq_encode u_enc (
        .sel  (sel),
        .code (code)
    );
endmodule

// File: rtl/srq_rate_regs.sv
module srq_rate_regs
    import srq_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] PLAY_IDX = 7'h2C,
    parameter logic [ADDR_W-1:0] CAP_IDX  = 7'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              var_rate_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] play_code,
    output logic [SEL_W-1:0]  play_sel,
    output logic [CODE_W-1:0] cap_code,
    output logic [SEL_W-1:0]  cap_sel
);
    localparam int NCH = 2;
    localparam logic [ADDR_W-1:0] IDX_TAB [NCH] = '{PLAY_IDX, CAP_IDX};

    rate_sel_e         sel_w  [NCH];
    logic [CODE_W-1:0] code_w [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        srq_chan #(
            .ADDR_W (ADDR_W),
            .IDX    (IDX_TAB[g])
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .vr_en   (var_rate_en),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .sel     (sel_w[g]),
            .code    (code_w[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NCH; k++) begin
            if (rd_addr == IDX_TAB[k]) rd_data = code_w[k];
        end
    end

    assign play_code = code_w[0];
    assign play_sel  = sel_w[0];
    assign cap_code  = code_w[1];
    assign cap_sel   = sel_w[1];
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] PLAY_IDX = 7'h2C,
    parameter logic [ADDR_W-1:0] CAP_IDX  = 7'h32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              var_rate_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [15:0]       rd_data,
    input logic [15:0]       play_code,
    input logic [2:0]        play_sel,
    input logic [15:0]       cap_code,
    input logic [2:0]        cap_sel
);
    function automatic logic [15:0] exp_code(input logic [3:0] n);
        case (n)
            4'h0, 4'h1:       return 16'h1F40;
            4'h2:             return 16'h2B11;
            4'h3:             return 16'h3E80;
            4'h4, 4'h5:       return 16'h5622;
            4'h6, 4'h7:       return 16'h7D00;
            4'h8, 4'h9, 4'hA: return 16'hAC44;
            default:          return 16'hBB80;
        endcase
    endfunction

    function automatic logic [15:0] sel_code(input logic [2:0] s);
        case (s)
            3'd0:    return 16'h1F40;
            3'd1:    return 16'h2B11;
            3'd2:    return 16'h3E80;
            3'd3:    return 16'h5622;
            3'd4:    return 16'h7D00;
            3'd5:    return 16'hAC44;
            3'd6:    return 16'hBB80;
            default: return 16'h0000;
        endcase
    endfunction

    p_play_snap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (var_rate_en && wr_en && wr_addr == PLAY_IDX)
        |=> (!var_rate_en || play_code == exp_code($past(wr_data[15:12]))));

    p_cap_snap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (var_rate_en && wr_en && wr_addr == CAP_IDX)
        |=> (!var_rate_en || cap_code == exp_code($past(wr_data[15:12]))));

    p_play_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (var_rate_en && !(wr_en && wr_addr == PLAY_IDX))
        |=> (!var_rate_en || $stable(play_code)));

    p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (var_rate_en && !(wr_en && wr_addr == CAP_IDX))
        |=> (!var_rate_en || $stable(cap_code)));

    p_disabled_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !var_rate_en |-> (play_code == 16'hBB80 && cap_code == 16'hBB80));

    p_reenable_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(var_rate_en) |-> (play_code == 16'hBB80 && cap_code == 16'hBB80));

    p_other_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != PLAY_IDX && rd_addr != CAP_IDX) |-> rd_data == 16'h0000);

    p_sel_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code(play_sel) == play_code) && (sel_code(cap_sel) == cap_code));
endmodule

bind srq_rate_regs srq_checker #(
    .ADDR_W   (ADDR_W),
    .PLAY_IDX (PLAY_IDX),
    .CAP_IDX  (CAP_IDX)
) u_chk (.*);

// File: tb/srq_rate_regs_test.sv
module srq_rate_regs_test;
    localparam logic [6:0] PI = 7'h2C;
    localparam logic [6:0] CI = 7'h32;

    typedef struct packed {
        logic [6:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [2:0]  sel;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{PI, 16'h0000, 16'h1F40, 3'd0},
        '{CI, 16'h1FFF, 16'h1F40, 3'd0},
        '{PI, 16'h2000, 16'h2B11, 3'd1},
        '{CI, 16'h2B11, 16'h2B11, 3'd1},
        '{PI, 16'h3000, 16'h3E80, 3'd2},
        '{PI, 16'h3FFF, 16'h3E80, 3'd2},
        '{CI, 16'h4000, 16'h5622, 3'd3},
        '{PI, 16'h5FFF, 16'h5622, 3'd3},
        '{CI, 16'h6000, 16'h7D00, 3'd4},
        '{PI, 16'h7FFF, 16'h7D00, 3'd4},
        '{CI, 16'h8000, 16'hAC44, 3'd5},
        '{PI, 16'hAFFF, 16'hAC44, 3'd5},
        '{CI, 16'hB000, 16'hBB80, 3'd6},
        '{PI, 16'hFFFF, 16'hBB80, 3'd6},
        '{CI, 16'h9ABC, 16'hAC44, 3'd5},
        '{PI, 16'h1234, 16'h1F40, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        var_rate_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data, play_code, cap_code;
    logic [2:0]  play_sel, cap_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    srq_rate_regs uut (
        .clk (clk), .rst_n (rst_n), .var_rate_en (var_rate_en),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .play_code (play_code), .play_sel (play_sel),
        .cap_code (cap_code), .cap_sel (cap_sel)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [6:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        var_rate_en = v;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        read_chk("R1 play reset", PI, 16'hBB80);
        read_chk("R1 cap reset", CI, 16'hBB80);
        check("R1 play_sel reset", {13'd0, play_sel}, 16'd6);
        check("R1 cap_sel reset", {13'd0, cap_sel}, 16'd6);
        rst_n = 1'b1;
        set_en(1'b1);

        // R2 R3 R8 R9: table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].data);
            read_chk($sformatf("R2 R3 R8 vec%0d", i), VECS[i].addr, VECS[i].exp);
            if (VECS[i].addr == PI) begin
                check($sformatf("R9 play_sel vec%0d", i), {13'd0, play_sel}, {13'd0, VECS[i].sel});
                check($sformatf("R9 play_code vec%0d", i), play_code, VECS[i].exp);
            end else begin
                check($sformatf("R9 cap_sel vec%0d", i), {13'd0, cap_sel}, {13'd0, VECS[i].sel});
                check($sformatf("R9 cap_code vec%0d", i), cap_code, VECS[i].exp);
            end
        end

        // R4: independence of the two registers
        do_write(PI, 16'h6000);
        do_write(CI, 16'h2000);
        read_chk("R4 play kept", PI, 16'h7D00);
        read_chk("R4 cap written", CI, 16'h2B11);
        do_write(PI, 16'h0000);
        read_chk("R4 cap kept", CI, 16'h2B11);

        // R7: other indices
        do_write(7'h2A, 16'hB000);
        do_write(7'h2E, 16'h8000);
        read_chk("R7 play untouched", PI, 16'h1F40);
        read_chk("R7 cap untouched", CI, 16'h2B11);
        read_chk("R7 other read", 7'h2A, 16'h0000);
        read_chk("R7 other read 2", 7'h7F, 16'h0000);

        // R8: visible exactly one edge after the strobe
        @(negedge clk);
        wr_en = 1'b1; wr_addr = CI; wr_data = 16'h8123;
        rd_addr = CI;
        #1;
        check("R8 before edge", rd_data, 16'h2B11);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 after edge", rd_data, 16'hAC44);

        // R5: disabled -> forced default, writes dropped
        set_en(1'b0);
        read_chk("R5 play forced", PI, 16'hBB80);
        read_chk("R5 cap forced", CI, 16'hBB80);
        do_write(PI, 16'h3000);
        do_write(CI, 16'h4000);
        read_chk("R5 play write ignored", PI, 16'hBB80);
        check("R5 cap_code ignored", cap_code, 16'hBB80);
        check("R5 play_sel forced", {13'd0, play_sel}, 16'd6);

        // R6: re-enable starts at default
        set_en(1'b1);
        read_chk("R6 play reenabled", PI, 16'hBB80);
        read_chk("R6 cap reenabled", CI, 16'hBB80);
        check("R6 cap_sel reenabled", {13'd0, cap_sel}, 16'd6);
        do_write(PI, 16'h2FFF);
        read_chk("R6 write after reenable", PI, 16'h2B11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule